// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences the digital side of a successive-approximation converter. It divides the system clock into ADC clock ticks. Each tick is a one-cycle enable pulse, and a second pulse marks the middle of each ADC clock period. Software sets a start bit, and the block schedules the sample-and-hold strobe and the result write on the ADC tick grid. At the write it captures an abstract data word into a result register and raises a sticky completion flag.

The first conversion after the block is enabled carries a warm-up phase. This phase moves the sample point later and stretches the conversion. Later conversions are shorter. In single mode each conversion is followed by one idle recovery tick before the next one may start. In free-run mode conversions chain back to back and the start bit stays set. Dropping the enable input stops the prescaler, aborts any conversion in flight and re-arms the warm-up phase.

Top module: `adc_seq_top`

## Requirements
- R1: The ADC tick period is 2^(s+1) system cycles, where s = min(`div_sel`, 6). This gives divide-by-2 for `div_sel` = 0 up to divide-by-128 for 6 or 7. While `enable` is low the prescaler is held at zero and no strobe, write or sample is produced.
- R2: A conversion starts at the first ADC tick that finds the start bit already set. A tick in the same system cycle as the `start_set` pulse does not start it.
- R3: In a normal conversion the sample strobe fires half a tick after ADC cycle 1 begins. It therefore precedes the result write by 11.5 ticks and never coincides with it.
- R4: A normal conversion writes at its 13th tick, counting the start tick as 1. At that write `result` takes the value of `data_in` and `done_flag` rises together with the `result_wr` pulse.
- R5: In single mode a conversion occupies 14 ticks. If the start bit is set again during the recovery tick, the next result write comes exactly 14 ticks after the previous one.
- R6: In free-run mode the next conversion starts on the tick right after a write, so result writes are 13 ticks apart.
- R7: The first conversion after enable samples at tick 13.5 and writes at tick 25. Counted from the system cycle in which `enable` and `start_set` are first high, the sample comes 13.5·P cycles later and the write 25·P cycles later, where P is the tick period.
- R8: `start_q` reads 1 throughout a conversion. In single mode it clears at the write unless `start_set` is high in that cycle. In free-run mode it stays set.
- R9: Lowering `enable` aborts a conversion without a write and clears `start_q`. The next enable repeats the 25-tick warm-up conversion.
- R10: `done_flag` is sticky until a `flag_clr` pulse. A write in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Converter enable; low holds prescaler and aborts |
| start_set | input | 1 | One-cycle pulse that sets the start bit |
| free_run | input | 1 | 1 = chain conversions, 0 = single conversion |
| div_sel | input | 3 | Prescaler ratio select |
| flag_clr | input | 1 | Pulse that clears the completion flag |
| data_in | input | 10 | Conversion value captured at the result write |
| start_q | output | 1 | Start bit readback, 1 while converting |
| sample_strobe | output | 1 | One-cycle sample-and-hold strobe |
| result_wr | output | 1 | One-cycle result write strobe |
| done_flag | output | 1 | Sticky conversion-complete flag |
| result | output | 10 | Result register |

## Verification
The block is driven through five patterns:
- a warm-up conversion in single mode;
- a restart placed inside the recovery tick;
- a start issued from idle at an arbitrary phase of the prescaler;
- a free-run chain;
- an enable drop in the middle of a conversion.

The warm-up pattern tells the 25-tick first conversion apart from the 13-tick normal one. The recovery restart tells the 14-tick single spacing apart from the 13-tick free-run spacing. The idle start shows whether the start waits for the next tick or is taken in the write cycle itself. Several prescaler ratios are tried, including the clamped top setting, so that a wrong division ratio shows up as a shifted write time.

// File: rtl/adc_seq_pkg.sv
// Shared types and cycle constants for the ADC conversion sequencer.
// Assumes ADC cycle numbers are counted with the start tick as cycle 1.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_RECOV = 2'd2
    } seq_state_t;

    // Width of the ADC cycle counter; must hold WARM_LAST.
    localparam int CYC_W       = 5;
    // Tick number whose mid-point carries the sample strobe.
    localparam int NORM_SAMPLE = 1;
    localparam int WARM_SAMPLE = 13;
    // Tick number on which the result is written.
    localparam int NORM_LAST   = 13;
    localparam int WARM_LAST   = 25;

endpackage

// File: rtl/adc_tick_gen.sv
// ADC clock prescaler.
// Produces a one-cycle 'tick' at the end of each ADC clock period and a
// one-cycle 'half' at its mid-point. Period is 2^(sel+1) system cycles,
// with sel clamped to MAX_SEL. Held at zero whenever enable is low.
module adc_tick_gen #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick,
    output logic             half
);
    localparam int CNT_W = MAX_SEL + 1;

    logic [SEL_W-1:0] sel_c;
    logic [CNT_W:0]   full_div;
    logic [CNT_W-1:0] div_m1;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt;

    // Clamp the select and derive terminal and mid-point counts.
    always_comb begin
        sel_c    = (div_sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : div_sel;
        full_div = (CNT_W+1)'(1) << (sel_c + 1'b1);
        div_m1   = CNT_W'(full_div - 1'b1);
        half_m1  = CNT_W'((full_div >> 1) - 1'b1);
        tick     = enable && (cnt >= div_m1);
        half     = enable && (cnt == half_m1);
    end

    // Free-running divider counter, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (cnt >= div_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_conv_fsm.sv
// Conversion scheduler.
// Holds the start bit, counts ADC ticks within a conversion and decides
// the sample and write points. The first conversion after enable uses the
// warm-up schedule. Assumes tick and half never fall in the same cycle.
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int CW = CYC_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic half,
    input  logic start_set,
    input  logic free_run,
    output logic start_q,
    output logic wr_fire,
    output logic smp_pulse,
    output logic wr_pulse
);
    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] last_c;
    logic [CW-1:0] samp_c;
    logic          warm;

    // Select the schedule and flag the write tick.
    always_comb begin
        last_c  = warm ? CW'(WARM_LAST)   : CW'(NORM_LAST);
        samp_c  = warm ? CW'(WARM_SAMPLE) : CW'(NORM_SAMPLE);
        cnt_nx  = cnt + 1'b1;
        wr_fire = enable && tick && (state == ST_RUN) && (cnt_nx == last_c);
    end

    // State, tick count, start bit and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            warm      <= 1'b1;
            start_q   <= 1'b0;
            smp_pulse <= 1'b0;
            wr_pulse  <= 1'b0;
        end else begin
            wr_pulse  <= wr_fire;
            smp_pulse <= half && (state == ST_RUN) && (cnt == samp_c);
            if (start_set) begin
                start_q <= 1'b1;
            end
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (start_q) begin
                            state <= ST_RUN;
                            cnt   <= CW'(1);
                        end
                    end
                    ST_RUN: begin
                        if (wr_fire) begin
                            warm <= 1'b0;
                            cnt  <= '0;
                            if (!free_run) begin
                                state   <= ST_RECOV;
                                start_q <= start_set;
                            end
                        end else begin
                            cnt <= cnt_nx;
                        end
                    end
                    ST_RECOV: state <= ST_IDLE;
                    default:  state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/adc_result_reg.sv
// Result register and sticky completion flag.
// Captures the data word on the write decision. The flag is set by a write
// and cleared by flag_clr, with the write taking priority.
module adc_result_reg #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              flag_clr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] result,
    output logic              done_flag
);
    // Capture the result word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (fire) begin
            result <= data_in;
        end
    end

    // Sticky completion flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (fire) begin
            done_flag <= 1'b1;
        end else if (flag_clr) begin
            done_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_seq_top.sv
// ADC conversion timing sequencer top level.
// Connects the prescaler, the scheduler and the result register.
// All inputs are assumed synchronous to clk.
module adc_seq_top #(
    parameter int DATA_W  = 10,
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_set,
    input  logic              free_run,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              flag_clr,
    input  logic [DATA_W-1:0] data_in,
    output logic              start_q,
    output logic              sample_strobe,
    output logic              result_wr,
    output logic              done_flag,
    output logic [DATA_W-1:0] result
);
    logic tick;
    logic half;
    logic wr_fire;

    adc_tick_gen #(
        .SEL_W   (SEL_W),
        .MAX_SEL (MAX_SEL)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_sel (div_sel),
        .tick    (tick),
        .half    (half)
    );

    adc_conv_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .half      (half),
        .start_set (start_set),
        .free_run  (free_run),
        .start_q   (start_q),
        .wr_fire   (wr_fire),
        .smp_pulse (sample_strobe),
        .wr_pulse  (result_wr)
    );

    adc_result_reg #(
        .DATA_W (DATA_W)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (wr_fire),
        .flag_clr  (flag_clr),
        .data_in   (data_in),
        .result    (result),
        .done_flag (done_flag)
    );

endmodule

// File: rtl/adc_seq_chk.sv
// Protocol checker for adc_seq_top, attached with bind.
// Observes ports only; assumes rst_n is synchronous and active low.
module adc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic start_set,
    input logic free_run,
    input logic flag_clr,
    input logic start_q,
    input logic sample_strobe,
    input logic result_wr,
    input logic done_flag
);
    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!result_wr && !sample_strobe && !start_q));

    // R3
    strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_strobe && result_wr));

    // R4
    wr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_wr |-> done_flag);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> start_q);

    // R8
    free_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_wr && $past(free_run)) |-> start_q);

    // R8
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_wr && !$past(free_run) && !$past(start_set)) |-> !start_q);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);

endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .start_set     (start_set),
    .free_run      (free_run),
    .flag_clr      (flag_clr),
    .start_q       (start_q),
    .sample_strobe (sample_strobe),
    .result_wr     (result_wr),
    .done_flag     (done_flag)
);

// File: tb/adc_seq_top_bench.sv
// Directed bench for adc_seq_top: one task per scenario.
module adc_seq_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       start_set = 1'b0;
    logic       free_run = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       flag_clr = 1'b0;
    logic [9:0] data_in = 10'd0;
    logic       start_q;
    logic       sample_strobe;
    logic       result_wr;
    logic       done_flag;
    logic [9:0] result;

    adc_seq_top u_adc_seq_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .start_set     (start_set),
        .free_run      (free_run),
        .div_sel       (div_sel),
        .flag_clr      (flag_clr),
        .data_in       (data_in),
        .start_q       (start_q),
        .sample_strobe (sample_strobe),
        .result_wr     (result_wr),
        .done_flag     (done_flag),
        .result        (result)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int wr_n = 0;
    int smp_n = 0;
    int wr_cyc = 0;
    int smp_cyc = 0;
    logic smp_st = 1'b0;
    logic [9:0] wr_val = '0;
    int c0 = 0;
    int divv = 2;
    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Event monitor, sampled shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && result_wr) begin
            wr_n   <= wr_n + 1;
            wr_cyc <= cyc;
            wr_val <= result;
        end
        if (rst_n && sample_strobe) begin
            smp_n   <= smp_n + 1;
            smp_cyc <= cyc;
            smp_st  <= start_q;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_wr(input int target, input int limit);
        for (int i = 0; i < limit && wr_n < target; i++) @(negedge clk);
        if (wr_n < target) chk(1'b0, "R4", "write timeout", wr_n, target);
    endtask

    task automatic enable_start(input int sel, input bit fr);
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        div_sel   = 3'(sel);
        free_run  = fr;
        divv      = 2 << ((sel > 6) ? 6 : sel);
        enable    = 1'b1;
        start_set = 1'b1;
        c0        = cyc;
        @(negedge clk);
        start_set = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_q == 1'b0, "R8", "start after reset", start_q, 0);
        chk(done_flag == 1'b0, "R10", "flag after reset", done_flag, 0);
        chk(result_wr == 1'b0 && sample_strobe == 1'b0, "R1", "strobes after reset",
            result_wr, 0);
    endtask

    // Warm-up conversion in single mode (R7, R4, R8).
    task automatic t_first_single(input int sel, input logic [9:0] val);
        int n0;
        int s0;
        n0 = wr_n;
        s0 = smp_n;
        data_in = val;
        enable_start(sel, 1'b0);
        chk(start_q == 1'b1, "R8", "start bit set", start_q, 1);
        wait_wr(n0 + 1, 40 * divv);
        chk(smp_n == s0 + 1, "R7", "one warm sample", smp_n, s0 + 1);
        chk(smp_cyc - c0 == 13 * divv + divv / 2, "R7", "warm sample time",
            smp_cyc - c0, 13 * divv + divv / 2);
        chk(wr_cyc - c0 == 25 * divv, "R7", "warm write time", wr_cyc - c0, 25 * divv);
        chk(wr_val == val, "R4", "result value", wr_val, val);
        chk(done_flag == 1'b1, "R4", "flag after write", done_flag, 1);
        chk(smp_st == 1'b1, "R8", "start bit while busy", smp_st, 1);
        chk(start_q == 1'b0, "R8", "single clears start", start_q, 0);
    endtask

    // Restart inside the recovery tick (R5, R3).
    task automatic t_recovery(input logic [9:0] val);
        int n0;
        int w0;
        n0 = wr_n;
        w0 = wr_cyc;
        data_in   = val;
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        wait_wr(n0 + 1, 20 * divv);
        chk(wr_cyc - w0 == 14 * divv, "R5", "single spacing", wr_cyc - w0, 14 * divv);
        chk(wr_cyc - smp_cyc == 12 * divv - divv / 2, "R3", "sample to write",
            wr_cyc - smp_cyc, 12 * divv - divv / 2);
        chk(wr_val == val, "R4", "second result", wr_val, val);
    endtask

    // Start from idle at an arbitrary prescaler phase (R2, R1, R10).
    task automatic t_idle_start(input int gap);
        int n0;
        int cs;
        int cst;
        n0 = wr_n;
        repeat (3 * divv + gap) @(negedge clk);
        chk(done_flag == 1'b1, "R10", "flag sticky when idle", done_flag, 1);
        cs  = cyc;
        cst = c0 + divv * ((cs + 2 - c0 + divv - 1) / divv);
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        wait_wr(n0 + 1, 20 * divv);
        chk(wr_cyc == cst + 12 * divv, "R2", "start waits for tick", wr_cyc,
            cst + 12 * divv);
    endtask

    // Clear the sticky flag (R10).
    task automatic t_flag();
        @(negedge clk);
        chk(done_flag == 1'b1, "R10", "flag held before clear", done_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(done_flag == 1'b0, "R10", "flag cleared", done_flag, 0);
        repeat (4) @(negedge clk);
        chk(done_flag == 1'b0, "R10", "flag stays clear", done_flag, 0);
    endtask

    // Free-run chain (R7, R6, R3, R8).
    task automatic t_free_run(input int sel);
        int n0;
        int w0;
        n0 = wr_n;
        data_in = 10'h155;
        enable_start(sel, 1'b1);
        wait_wr(n0 + 1, 40 * divv);
        chk(wr_cyc - c0 == 25 * divv, "R7", "free warm write", wr_cyc - c0, 25 * divv);
        w0 = wr_cyc;
        wait_wr(n0 + 2, 20 * divv);
        chk(wr_cyc - w0 == 13 * divv, "R6", "free spacing", wr_cyc - w0, 13 * divv);
        chk(wr_cyc - smp_cyc == 12 * divv - divv / 2, "R3", "free sample to write",
            wr_cyc - smp_cyc, 12 * divv - divv / 2);
        w0 = wr_cyc;
        wait_wr(n0 + 3, 20 * divv);
        chk(wr_cyc - w0 == 13 * divv, "R6", "free spacing again", wr_cyc - w0, 13 * divv);
        chk(start_q == 1'b1, "R8", "free keeps start", start_q, 1);
        @(negedge clk);
        enable   = 1'b0;
        free_run = 1'b0;
    endtask

    // Abort by enable drop, then re-armed warm-up (R9, R1).
    task automatic t_abort(input int sel);
        int n0;
        int s0;
        enable_start(sel, 1'b0);
        repeat (6 * divv) @(negedge clk);
        n0 = wr_n;
        enable = 1'b0;
        @(negedge clk);
        s0 = smp_n;
        repeat (30 * divv) @(negedge clk);
        chk(wr_n == n0, "R9", "no write after abort", wr_n, n0);
        chk(start_q == 1'b0, "R9", "start cleared on abort", start_q, 0);
        chk(smp_n == s0, "R1", "no sample while off", smp_n, s0);
        enable_start(sel, 1'b0);
        wait_wr(n0 + 1, 40 * divv);
        chk(wr_cyc - c0 == 25 * divv, "R9", "warm-up re-armed", wr_cyc - c0, 25 * divv);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_first_single(2, 10'h2A5);
        t_recovery(10'h0F3);
        t_idle_start(1);
        t_idle_start(6);
        t_flag();
        t_free_run(0);
        t_free_run(3);
        t_abort(1);
        t_first_single(7, 10'h3C1);
        t_recovery(10'h011);
        finish_run();
    end

endmodule